// File: doc/BRIEF.md
# DMA Page Register File

This block holds the page bytes that widen each of four DMA channels' 16-bit running address into a 31-bit physical address. Every channel has two bytes. The low page supplies address bits 23:16. The high page supplies bits 30:24, and only its lower seven bits are used.

Software reaches the bytes through a 3-bit port offset. A bank-select input chooses the low or the high bank. The offset does not map to channels in numeric order, and four of the eight offsets map to no channel at all. A configuration input turns the high bank on. When that input is low, the high bank's ports are not decoded.

A separate channel-select input picks one channel. Together with that channel's current 16-bit address, it produces the composed physical address on a combinational output.

Top module: `dma_page_regfile`

## Requirements
- R1: Synchronous active-high reset clears every low and high page byte and the read data register to zero.
- R2: Port offsets map to channels as follows: 1 to channel 2, 2 to channel 3, 3 to channel 1, and 7 to channel 0. A write strobe with bank_sel=0 stores wr_data into that channel's low page.
- R3: A write to offset 0, 4, 5 or 6 changes no page byte in either bank.
- R4: A read strobe at offset 0, 4, 5 or 6 puts zero on rd_data one cycle later.
- R5: A read strobe at a valid offset puts the addressed byte, all 8 bits, on rd_data one cycle later. rd_data holds its value in every cycle that has no read strobe.
- R6: With high_bank_en=1 and bank_sel=1, the same offset map reaches a separate high page byte for each channel.
- R7: With high_bank_en=0, a write with bank_sel=1 is discarded, and a read with bank_sel=1 returns zero.
- R8: phys_addr is built from three fields. Bits 30:24 are bits 6:0 of the selected channel's high page, bits 23:16 are its low page, and bits 15:0 are cur_addr. Bit 7 of the high page never reaches the address.
- R9: While high_bank_en=0, phys_addr bits 30:24 are zero, even if a high page byte is nonzero.
- R10: When a read and a write hit the same byte in one cycle, the read returns the value the byte held before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| high_bank_en | input | 1 | Configuration: enables the high page bank |
| acc_wr | input | 1 | Single-cycle write strobe |
| acc_rd | input | 1 | Single-cycle read strobe |
| bank_sel | input | 1 | Bank select: 0 for low page, 1 for high page |
| port_off | input | 3 | Page port offset |
| wr_data | input | 8 | Write byte |
| rd_data | output | 8 | Read byte, registered |
| sel_chan | input | 2 | Channel whose address is composed |
| cur_addr | input | 16 | Current 16-bit address of the selected channel |
| phys_addr | output | 31 | Composed physical address |

## Verification
A write lands at the clock edge on which its strobe is sampled. phys_addr is combinational from the stored bytes, so its effect shows as soon as that edge has passed. Read data is registered and is due exactly one edge after the read strobe; it then holds until the next read strobe. The bench drives every strobe on the falling edge and lifts it on the next falling edge. It samples phys_addr and rd_data on that same falling edge, one rising edge after the stimulus, and so lands between edges where each result is due.

// File: rtl/dma_page_pkg.sv
package dma_page_pkg;
    localparam int NUM_CH   = 4;
    localparam int CH_W     = $clog2(NUM_CH);
    localparam int NUM_BANK = 2;
    localparam int OFF_W    = 3;
    localparam int PAGE_W   = 8;
    localparam int HI_KEEP  = 7;
    localparam int ADDR_W   = 16;

    typedef struct packed {
        logic            hit;
        logic [CH_W-1:0] chan;
    } page_sel_t;

    // Sparse offset-to-channel map; unlisted offsets decode to no channel.
    function automatic page_sel_t map_offset(input logic [OFF_W-1:0] off);
        page_sel_t s;
        s.hit  = 1'b1;
        s.chan = '0;
        case (off)
            3'd1:    s.chan = CH_W'(2);
            3'd2:    s.chan = CH_W'(3);
            3'd3:    s.chan = CH_W'(1);
            3'd7:    s.chan = CH_W'(0);
            default: s.hit  = 1'b0;
        endcase
        return s;
    endfunction
endpackage

// File: rtl/page_port_decode.sv
module page_port_decode
    import dma_page_pkg::*;
(
    input  logic                 acc_wr,
    input  logic                 bank_sel,
    input  logic                 high_bank_en,
    input  logic [OFF_W-1:0]     port_off,
    output page_sel_t            sel,
    output logic                 bank_ok,
    output logic [NUM_BANK-1:0]  wr_en
);
    always_comb begin
        sel     = map_offset(port_off);
        bank_ok = !bank_sel || high_bank_en;
        for (int b = 0; b < NUM_BANK; b++) begin
            wr_en[b] = acc_wr && sel.hit && bank_ok && (bank_sel == b[0]);
        end
    end
endmodule

// File: rtl/page_bank.sv
module page_bank
    import dma_page_pkg::*;
#(
    parameter int W = PAGE_W
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            wr_en,
    input  logic [CH_W-1:0] wr_chan,
    input  logic [W-1:0]    wr_data,
    input  logic [CH_W-1:0] rd_chan,
    output logic [W-1:0]    rd_val,
    input  logic [CH_W-1:0] view_chan,
    output logic [W-1:0]    view_val
);
    logic [W-1:0] pages [NUM_CH];

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        always_ff @(posedge clk) begin
            if (rst) begin
                pages[c] <= '0;
            end else if (wr_en && (wr_chan == CH_W'(c))) begin
                pages[c] <= wr_data;
            end
        end
    end

    assign rd_val   = pages[rd_chan];
    assign view_val = pages[view_chan];
endmodule

// File: rtl/page_addr_compose.sv
module page_addr_compose
    import dma_page_pkg::*;
(
    input  logic                          hi_en,
    input  logic [PAGE_W-1:0]             hi_page,
    input  logic [PAGE_W-1:0]             lo_page,
    input  logic [ADDR_W-1:0]             cur_addr,
    output logic [HI_KEEP+PAGE_W+ADDR_W-1:0] phys_addr
);
    logic [HI_KEEP-1:0] hi_bits;

    always_comb begin
        hi_bits   = hi_en ? hi_page[HI_KEEP-1:0] : '0;
        phys_addr = {hi_bits, lo_page, cur_addr};
    end
endmodule

// File: rtl/dma_page_regfile.sv
module dma_page_regfile
    import dma_page_pkg::*;
(
    input  logic                             clk,
    input  logic                             rst,
    input  logic                             high_bank_en,
    input  logic                             acc_wr,
    input  logic                             acc_rd,
    input  logic                             bank_sel,
    input  logic [OFF_W-1:0]                 port_off,
    input  logic [PAGE_W-1:0]                wr_data,
    output logic [PAGE_W-1:0]                rd_data,
    input  logic [CH_W-1:0]                  sel_chan,
    input  logic [ADDR_W-1:0]                cur_addr,
    output logic [HI_KEEP+PAGE_W+ADDR_W-1:0] phys_addr
);
    page_sel_t             sel;
    logic                  bank_ok;
    logic [NUM_BANK-1:0]   wr_en;
    logic [PAGE_W-1:0]     bank_rd   [NUM_BANK];
    logic [PAGE_W-1:0]     bank_view [NUM_BANK];

    page_port_decode u_dec (
        .acc_wr       (acc_wr),
        .bank_sel     (bank_sel),
        .high_bank_en (high_bank_en),
        .port_off     (port_off),
        .sel          (sel),
        .bank_ok      (bank_ok),
        .wr_en        (wr_en)
    );

    for (genvar b = 0; b < NUM_BANK; b++) begin : g_bank
        page_bank #(.W(PAGE_W)) u_bank (
            .clk       (clk),
            .rst       (rst),
            .wr_en     (wr_en[b]),
            .wr_chan   (sel.chan),
            .wr_data   (wr_data),
            .rd_chan   (sel.chan),
            .rd_val    (bank_rd[b]),
            .view_chan (sel_chan),
            .view_val  (bank_view[b])
        );
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_data <= '0;
        end else if (acc_rd) begin
            rd_data <= (sel.hit && bank_ok) ? bank_rd[bank_sel] : '0;
        end
    end

    page_addr_compose u_comp (
        .hi_en     (high_bank_en),
        .hi_page   (bank_view[1]),
        .lo_page   (bank_view[0]),
        .cur_addr  (cur_addr),
        .phys_addr (phys_addr)
    );
endmodule

// File: rtl/dma_page_regfile_chk.sv
module dma_page_regfile_chk
    import dma_page_pkg::*;
(
    input logic                             clk,
    input logic                             rst,
    input logic                             high_bank_en,
    input logic                             acc_rd,
    input logic                             bank_sel,
    input logic [OFF_W-1:0]                 port_off,
    input logic [PAGE_W-1:0]                rd_data,
    input logic [HI_KEEP+PAGE_W+ADDR_W-1:0] phys_addr
);
    logic dead_off;
    assign dead_off = (port_off == 3'd0) || (port_off == 3'd4) ||
                      (port_off == 3'd5) || (port_off == 3'd6);

    AST_RESET_CLEARS_PAGES: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (phys_addr[HI_KEEP+PAGE_W+ADDR_W-1:ADDR_W] == '0 && rd_data == '0)); // R1
    AST_DEAD_OFFSET_READS_ZERO: assert property (@(posedge clk) disable iff (rst)
        (acc_rd && dead_off) |=> (rd_data == '0)); // R4
    AST_RD_DATA_HOLDS: assert property (@(posedge clk) disable iff (rst)
        !acc_rd |=> $stable(rd_data)); // R5
    AST_HI_BANK_OFF_READS_ZERO: assert property (@(posedge clk) disable iff (rst)
        (acc_rd && bank_sel && !high_bank_en) |=> (rd_data == '0)); // R7
    AST_HI_BANK_OFF_NO_HIGH_BITS: assert property (@(posedge clk) disable iff (rst)
        !high_bank_en |-> (phys_addr[HI_KEEP+PAGE_W+ADDR_W-1:PAGE_W+ADDR_W] == '0)); // R9
endmodule

bind dma_page_regfile dma_page_regfile_chk u_chk (
    .clk          (clk),
    .rst          (rst),
    .high_bank_en (high_bank_en),
    .acc_rd       (acc_rd),
    .bank_sel     (bank_sel),
    .port_off     (port_off),
    .rd_data      (rd_data),
    .phys_addr    (phys_addr)
);

// File: tb/tb_dma_page_regfile.sv
module tb_dma_page_regfile;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        high_bank_en = 1'b0;
    logic        acc_wr = 1'b0;
    logic        acc_rd = 1'b0;
    logic        bank_sel = 1'b0;
    logic [2:0]  port_off = '0;
    logic [7:0]  wr_data = '0;
    logic [7:0]  rd_data;
    logic [1:0]  sel_chan = '0;
    logic [15:0] cur_addr = '0;
    logic [30:0] phys_addr;

    int n_chk = 0;
    int n_fail = 0;

    always #2 clk = ~clk;

    dma_page_regfile dut (
        .clk(clk), .rst(rst), .high_bank_en(high_bank_en), .acc_wr(acc_wr),
        .acc_rd(acc_rd), .bank_sel(bank_sel), .port_off(port_off),
        .wr_data(wr_data), .rd_data(rd_data), .sel_chan(sel_chan),
        .cur_addr(cur_addr), .phys_addr(phys_addr)
    );

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic do_write(input bit bk, input logic [2:0] off, input logic [7:0] d);
        @(negedge clk);
        bank_sel = bk; port_off = off; wr_data = d; acc_wr = 1'b1;
        @(negedge clk);
        acc_wr = 1'b0;
    endtask

    task automatic do_read(input bit bk, input logic [2:0] off, output logic [7:0] d);
        @(negedge clk);
        bank_sel = bk; port_off = off; acc_rd = 1'b1;
        @(negedge clk);
        acc_rd = 1'b0;
        d = rd_data;
    endtask

    task automatic low_page_of(input logic [1:0] ch, output logic [7:0] p);
        sel_chan = ch;
        #1;
        p = phys_addr[23:16];
    endtask

    task automatic t_reset;
        logic [7:0] p;
        for (int c = 0; c < 4; c++) begin
            low_page_of(2'(c), p);
            check(p == 8'h00 && phys_addr[30:24] == 7'h00, "R1 pages zero", {1'b0, phys_addr}, 32'h0);
        end
        check(rd_data == 8'h00, "R1 rd_data zero", rd_data, 0);
    endtask

    task automatic t_map_low;
        logic [7:0] p;
        do_write(0, 3'd1, 8'h11);
        do_write(0, 3'd2, 8'h12);
        do_write(0, 3'd3, 8'h13);
        do_write(0, 3'd7, 8'h17);
        low_page_of(2'd2, p); check(p == 8'h11, "R2 off1->ch2", p, 8'h11);
        low_page_of(2'd3, p); check(p == 8'h12, "R2 off2->ch3", p, 8'h12);
        low_page_of(2'd1, p); check(p == 8'h13, "R2 off3->ch1", p, 8'h13);
        low_page_of(2'd0, p); check(p == 8'h17, "R2 off7->ch0", p, 8'h17);
    endtask

    task automatic t_invalid;
        logic [7:0] p, d;
        logic [7:0] exp_pg [4];
        exp_pg[0] = 8'h17; exp_pg[1] = 8'h13; exp_pg[2] = 8'h11; exp_pg[3] = 8'h12;
        foreach (exp_pg[i]) begin end
        do_write(0, 3'd0, 8'hA0);
        do_write(0, 3'd4, 8'hA4);
        do_write(0, 3'd5, 8'hA5);
        do_write(0, 3'd6, 8'hA6);
        for (int c = 0; c < 4; c++) begin
            low_page_of(2'(c), p);
            check(p == exp_pg[c], "R3 dead write ignored", p, exp_pg[c]);
        end
        do_read(0, 3'd7, d);
        check(d == 8'h17, "R5 read ch0 low", d, 8'h17);
        do_read(0, 3'd5, d);
        check(d == 8'h00, "R4 dead offset reads zero", d, 0);
        do_read(0, 3'd3, d);
        check(d == 8'h13, "R5 read ch1 low", d, 8'h13);
        repeat (3) @(negedge clk);
        check(rd_data == 8'h13, "R5 rd_data holds", rd_data, 8'h13);
        do_read(0, 3'd0, d);
        check(d == 8'h00, "R4 offset0 reads zero", d, 0);
    endtask

    task automatic t_high_bank;
        logic [7:0] d;
        high_bank_en = 1'b1;
        cur_addr = 16'hBEEF;
        do_write(1, 3'd7, 8'hFF);
        do_write(1, 3'd1, 8'h2A);
        sel_chan = 2'd0; #1;
        check(phys_addr == {7'h7F, 8'h17, 16'hBEEF}, "R8 ch0 compose, bit7 dropped", {1'b0, phys_addr}, {1'b0, 7'h7F, 8'h17, 16'hBEEF});
        sel_chan = 2'd2; #1;
        check(phys_addr == {7'h2A, 8'h11, 16'hBEEF}, "R6 high off1->ch2", {1'b0, phys_addr}, {1'b0, 7'h2A, 8'h11, 16'hBEEF});
        do_read(1, 3'd7, d);
        check(d == 8'hFF, "R6 high read full byte", d, 8'hFF);
        sel_chan = 2'd3; #1;
        check(phys_addr[30:24] == 7'h00, "R6 high ch3 untouched", {25'h0, phys_addr[30:24]}, 0);
    endtask

    task automatic t_high_disabled;
        logic [7:0] d;
        high_bank_en = 1'b0;
        sel_chan = 2'd0; #1;
        check(phys_addr[30:24] == 7'h00, "R9 high bits zero when disabled", {25'h0, phys_addr[30:24]}, 0);
        do_read(1, 3'd7, d);
        check(d == 8'h00, "R7 disabled high read zero", d, 0);
        do_write(1, 3'd7, 8'h05);
        high_bank_en = 1'b1;
        #1;
        check(phys_addr[30:24] == 7'h7F, "R7 disabled high write discarded", {25'h0, phys_addr[30:24]}, 32'h7F);
    endtask

    task automatic t_same_cycle;
        logic [7:0] d;
        @(negedge clk);
        bank_sel = 1'b0; port_off = 3'd2; wr_data = 8'h5C; acc_wr = 1'b1; acc_rd = 1'b1;
        @(negedge clk);
        acc_wr = 1'b0; acc_rd = 1'b0;
        check(rd_data == 8'h12, "R10 read sees old value", rd_data, 8'h12);
        do_read(0, 3'd2, d);
        check(d == 8'h5C, "R10 write then lands", d, 8'h5C);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_map_low();
        t_invalid();
        t_high_bank();
        t_high_disabled();
        t_same_cycle();
        @(negedge clk);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        #800000;
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule